// File: doc/BRIEF.md
# Partitioned Packed-Lane Adder

This block adds two 64-bit operands either as one full-width integer or as a set of narrower packed integers sharing the same word. A two-bit lane-size input picks 8, 16, 32 or 64-bit lanes. The one datapath therefore performs eight, four, two or one independent additions. The adder is built from 8-bit slices. At every lane boundary the carry between slices is cut and replaced by the lane's own carry-in, so every lane wraps modulo its own width and never disturbs its neighbour. A subtract control turns each lane into a difference, A minus B, by complementing B and forcing a carry-in of one at the bottom of every lane.

The lane count follows only from the lane-size input. No per-lane enable or mask exists. Every lane reports its carry-out on an 8-bit vector indexed by slice. The result is held in a single output register with a valid/ready handshake on both sides. An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so full throughput is reached when the consumer keeps `out_ready` high. While `out_valid` is high and `out_ready` is low, the output holds its value and no new operands are taken.

Top module: `packed_lane_adder`

## Requirements
- R1: With `in_mode` = 2'b00 the word is eight 8-bit lanes (bits 8k+7..8k). Each lane's sum is (A+B) mod 256, and no carry passes between lanes.
- R2: With `in_mode` = 2'b01 the word is four 16-bit lanes, each summed modulo 2^16.
- R3: With `in_mode` = 2'b10 the word is two 32-bit lanes, each summed modulo 2^32.
- R4: With `in_mode` = 2'b11 the word is one 64-bit lane summed modulo 2^64.
- R5: With `in_sub` = 1 every active lane computes A + ~B + 1, which is A minus B modulo the lane width. A difference of equal operands is zero with every lane carry set.
- R6: Bit i of `out_carry` is the carry out of the top bit of the lane whose most significant slice is slice i (bits 8i+7..8i). For subtraction this carry means "no borrow". Bits at slices that do not end a lane read 0.
- R7: After reset `out_valid` is 0 and `in_ready` is 1.
- R8: An operand pair accepted on a clock edge appears on `out_sum`/`out_carry` with `out_valid` = 1 right after that edge.
- R9: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and `out_sum`, `out_carry` and `out_valid` hold their values across the edge.
- R10: Results leave in the order their operands were accepted, each exactly once. When `out_ready` = 1 a new pair can be taken in the same cycle the old result leaves. With no new pair, `out_valid` falls after a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_mode | input | 2 | Lane size: 00=8, 01=16, 10=32, 11=64 bits |
| in_sub | input | 1 | 1 = subtract B from A in every lane |
| in_a | input | 64 | Packed operand A |
| in_b | input | 64 | Packed operand B |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | 64 | Packed lane results |
| out_carry | output | 8 | Per-lane carry-out, indexed by ending slice |

## Verification
The bench builds the block with its default 64-bit word and 8-bit slice. This gives all four lane sizes, including the single full-width lane in which the carry crosses every slice joint. Operands of all ones plus one, and equal-operand differences, drive carries right up to each boundary so a leak between lanes would show. A randomly throttled `out_ready` exercises stalls, same-cycle refill and draining against a queue-based reference model.

// File: rtl/pla_pkg.sv
package pla_pkg;

  localparam int unsigned PLA_DATA_W_DEF  = 64;
  localparam int unsigned PLA_SLICE_W_DEF = 8;

  // number of slices spanned by one lane for a given lane-size code
  function automatic int unsigned pla_span(input int unsigned code);
    return 32'd1 << code;
  endfunction

endpackage

// File: rtl/pla_boundary_gen.sv
module pla_boundary_gen
  import pla_pkg::*;
#(
  parameter int unsigned NSLICE = 8,
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  output logic [NSLICE-1:0] lane_start,
  output logic [NSLICE-1:0] lane_end
);

  always_comb begin
    int unsigned span;
    span = pla_span(int'(mode));
    for (int s = 0; s < NSLICE; s++) begin
      lane_start[s] = ((s & (span - 1)) == 0);
      lane_end[s]   = (((s + 1) & (span - 1)) == 0);
    end
  end

  // lane ends count equals the number of lanes the mode asks for
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_end) == (NSLICE >> mode)) else $error("lane count"); // R6

  // the bottom slice always opens a lane
  AST_BOTTOM_START: assert property (@(posedge clk) disable iff (!rst_n)
    lane_start[0]) else $error("bottom start"); // R1

endmodule

// File: rtl/pla_slice_chain.sv
module pla_slice_chain #(
  parameter int unsigned NSLICE  = 8,
  parameter int unsigned SLICE_W = 8,
  localparam int unsigned DATA_W = NSLICE * SLICE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [NSLICE-1:0] lane_start,
  input  logic [NSLICE-1:0] lane_end,
  output logic [DATA_W-1:0] sum,
  output logic [NSLICE-1:0] carry
);

  logic [NSLICE-1:0] slice_cout;
  logic [NSLICE-1:0] slice_cin;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic [SLICE_W-1:0] a_s, b_s, r_s;
    logic               c_s;
    logic               prev_c;

    if (s == 0) begin : g_first
      assign prev_c = sub;
    end else begin : g_rest
      assign prev_c = slice_cout[s-1];
    end

    assign a_s          = a[s*SLICE_W +: SLICE_W];
    assign b_s          = sub ? ~b[s*SLICE_W +: SLICE_W] : b[s*SLICE_W +: SLICE_W];
    assign slice_cin[s] = lane_start[s] ? sub : prev_c;
    assign {c_s, r_s}   = {1'b0, a_s} + {1'b0, b_s} + {{SLICE_W{1'b0}}, slice_cin[s]};
    assign slice_cout[s] = c_s;
    assign sum[s*SLICE_W +: SLICE_W] = r_s;
    assign carry[s] = lane_end[s] & c_s;
  end

  // a minus itself gives zero and a carry at every lane end
  AST_SELF_SUB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sub && a == b) |-> (sum == '0 && carry == lane_end)) else $error("self sub"); // R5

endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NSLICE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d_sum,
  input  logic [NSLICE-1:0] d_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_sum,
  output logic [NSLICE-1:0] out_carry
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_carry <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_sum   <= d_sum;
      out_carry <= d_carry;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid) else $error("no result"); // R8

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_carry)))
    else $error("stall lost data"); // R9

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid) else $error("drain"); // R10

endmodule

// File: rtl/packed_lane_adder.sv
module packed_lane_adder
  import pla_pkg::*;
#(
  parameter int unsigned DATA_W  = PLA_DATA_W_DEF,
  parameter int unsigned SLICE_W = PLA_SLICE_W_DEF,
  localparam int unsigned NSLICE = DATA_W / SLICE_W,
  localparam int unsigned MODE_W = $clog2($clog2(NSLICE) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MODE_W-1:0] in_mode,
  input  logic              in_sub,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_sum,
  output logic [NSLICE-1:0] out_carry
);

  logic [NSLICE-1:0] lane_start, lane_end;
  logic [DATA_W-1:0] raw_sum;
  logic [NSLICE-1:0] raw_carry;

  pla_boundary_gen #(.NSLICE(NSLICE), .MODE_W(MODE_W)) u_bound (
    .clk(clk), .rst_n(rst_n), .mode(in_mode),
    .lane_start(lane_start), .lane_end(lane_end)
  );

  pla_slice_chain #(.NSLICE(NSLICE), .SLICE_W(SLICE_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .a(in_a), .b(in_b), .sub(in_sub),
    .lane_start(lane_start), .lane_end(lane_end),
    .sum(raw_sum), .carry(raw_carry)
  );

  pla_out_stage #(.DATA_W(DATA_W), .NSLICE(NSLICE)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_sum(raw_sum), .d_carry(raw_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_carry(out_carry)
  );

  // carries never appear away from a lane end
  AST_CARRY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_carry & ~lane_end) == '0) else $error("stray carry"); // R6

  // in the full-width lane only the top slice may report a carry
  AST_WIDE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode == '1) |-> (raw_carry[NSLICE-2:0] == '0)) else $error("wide lane"); // R4

endmodule

// File: tb/test_packed_lane_adder.sv
`timescale 1ns/1ps
module test_packed_lane_adder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = 2'b00;
  logic        in_sub = 1'b0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_sum;
  logic [7:0]  out_carry;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [63:0] q_sum[$];
  logic [7:0]  q_cy[$];
  string       q_tag[$];

  logic        prev_stall = 0;
  logic [63:0] prev_sum;
  logic [7:0]  prev_cy;

  always #2.5 clk = ~clk;

  packed_lane_adder i_packed_lane_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_sub(in_sub), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_carry(out_carry)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model of the lane arithmetic
  task automatic ref_calc(input logic [1:0] m, input logic s, input logic [63:0] a,
                          input logic [63:0] b, output logic [63:0] sm, output logic [7:0] cy);
    int w, n;
    logic [64:0] mask, al, bl, t, hi;
    w = 8 << m;
    n = 8 >> m;
    sm = '0;
    cy = '0;
    mask = (65'd1 << w) - 65'd1;
    for (int l = 0; l < n; l++) begin
      al = ({1'b0, a} >> (l * w)) & mask;
      bl = ({1'b0, b} >> (l * w)) & mask;
      if (s) bl = ~bl & mask;
      t = al + bl + {64'd0, s};
      sm = sm | (((t & mask) << (l * w)) & 65'h0_FFFF_FFFF_FFFF_FFFF);
      hi = t >> w;
      cy[(l + 1) * (w / 8) - 1] = hi[0];
    end
  endtask

  function automatic string tag_of(input logic [1:0] m, input logic s);
    if (s) return "R5";
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  // one cycle: drive at negedge, settle, check, book accepted operands
  task automatic step(input logic v, input logic [1:0] m, input logic s,
                      input logic [63:0] a, input logic [63:0] b, input logic rdy);
    logic [63:0] es;
    logic [7:0]  ec;
    @(negedge clk);
    in_valid = v; in_mode = m; in_sub = s; in_a = a; in_b = b; out_ready = rdy;
    #1;
    if (prev_stall) begin
      check("R9 hold valid", {63'd0, out_valid}, 64'd1);
      check("R9 hold sum", out_sum, prev_sum);
      check("R9 hold carry", {56'd0, out_carry}, {56'd0, prev_cy});
    end
    if (out_valid && !out_ready)
      check("R9 ready low on stall", {63'd0, in_ready}, 64'd0);
    else
      check("R10 ready when free", {63'd0, in_ready}, 64'd1);
    if (out_valid != (q_sum.size() != 0))
      check("R8 valid vs pending", {63'd0, out_valid}, {63'd0, q_sum.size() != 0});
    if (out_valid && q_sum.size() != 0) begin
      check({q_tag[0], " sum"}, out_sum, q_sum[0]);
      check("R6 carry", {56'd0, out_carry}, {56'd0, q_cy[0]});
    end
    prev_stall = out_valid && !out_ready;
    prev_sum = out_sum;
    prev_cy = out_carry;
    if (out_valid && out_ready && q_sum.size() != 0) begin
      void'(q_sum.pop_front()); void'(q_cy.pop_front()); void'(q_tag.pop_front());
    end
    if (v && in_ready) begin
      ref_calc(m, s, a, b, es, ec);
      q_sum.push_back(es); q_cy.push_back(ec); q_tag.push_back(tag_of(m, s));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset valid", {63'd0, out_valid}, 64'd0);
    check("R7 reset ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // carry right up to every boundary: all-ones + one
    for (int m = 0; m < 4; m++) begin
      logic [63:0] one;
      one = '0;
      for (int l = 0; l < (8 >> m); l++) one[l * (8 << m)] = 1'b1;
      step(1, m[1:0], 0, '1, one, 1);
      step(1, m[1:0], 1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1);
      step(1, m[1:0], 1, '0, one, 1);
    end
    step(0, 2'b00, 0, '0, '0, 1);

    // R9 stall: hold output while ready is low, then same-cycle refill
    step(1, 2'b01, 0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0);
    step(1, 2'b10, 0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 0);
    step(1, 2'b10, 0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 0);
    step(1, 2'b10, 0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 1);
    step(0, 2'b00, 0, '0, '0, 1);
    step(0, 2'b00, 0, '0, '0, 1);
    check("R10 drained", {63'd0, out_valid}, 64'd0);

    // random traffic with throttled consumer
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (($urandom & 7) == 0) rb = ra;
      step(($urandom % 4) != 0, 2'($urandom), 1'($urandom), ra, rb, ($urandom % 3) != 0);
    end
    step(0, 2'b00, 0, '0, '0, 1);
    step(0, 2'b00, 0, '0, '0, 1);
    check("R10 queue empty", {32'd0, q_sum.size()}, 64'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule